// File: doc/BRIEF.md
# Gray-Network Thermometer Encoder

This block turns the thermometer word from a bank of flash comparators into a binary sample code. A thermometer of 2^BITS − 1 taps is captured on a sample strobe. A sparse network of two-input AND terms then forms a Gray word directly from fixed tap pairs, each term true when a lower tap is set and its partner higher up is clear. An XOR chain running from the most significant bit downward turns that Gray word into binary, which is registered together with a valid flag.

No ones-counter and no priority encoder is used. Every tap feeds exactly one Gray bit, so a single stray comparator flip disturbs at most one Gray bit. Bubbled, non-monotonic input is not corrected separately: the result is whatever the Gray equations give.

Top module: `therm_gray_enc`

## Requirements
- R1: While `rst` is high at a rising edge, `code_out` becomes 0 and `code_valid` becomes 0 on that edge.
- R2: A strobe (`sample_en` high at an edge) captures `therm_in`. `code_valid` is high exactly two edges later for one cycle per strobe. Strobes on consecutive cycles give results on consecutive cycles, in order.
- R3: Without a strobe, changes on `therm_in` have no effect: `code_out` holds its last value and `code_valid` stays low.
- R4: For a legal thermometer of level L (taps `therm_in[k-1]` set exactly for k ≤ L, bit 0 = tap 1), `code_out` equals L. Bit 0 is the LSB.
- R5: An all-zero thermometer gives 0. An all-ones thermometer gives 2^BITS − 1 (63 at default).
- R6: For any input, Gray bit j (0 ≤ j < BITS−1) is the OR over pairs of (tap (4m+1)·2^j set AND tap (4m+3)·2^j clear). The top Gray bit is tap 2^(BITS−1). `code_out` is the Gray word converted MSB-first by XOR ripple (b[top] = g[top], b[i] = b[i+1] ^ g[i]).
- R7: Flipping a single tap of a legal thermometer changes the Gray form of `code_out` (code ^ code>>1) in at most one bit, compared with the clean level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_en | input | 1 | Sample strobe, captures `therm_in` |
| therm_in | input | 2^BITS−1 | Thermometer taps, bit 0 = lowest level |
| code_out | output | BITS | Registered binary sample code |
| code_valid | output | 1 | One-cycle flag for a new `code_out` |

## Verification
All legal levels 0 to 63 are swept and compared with a count of ones. This separates a wrong tap pair or a wrong XOR direction from a correct network. Random single-tap bubbles are compared with an independent model of the pair equations. The same runs confirm that the Gray form moves by at most one bit, which catches a tap wired into two terms. Hold-without-strobe and back-to-back strobe runs separate capture gating and latency faults from encoding faults.

// File: rtl/tge_pkg.sv
package tge_pkg;
  localparam int unsigned DEF_BITS = 6;

  // number of AND pair terms feeding Gray bit j of a BITS-wide code
  function automatic int unsigned pair_terms(input int unsigned bits, input int unsigned j);
    return 1 << (bits - 2 - j);
  endfunction
endpackage

// File: rtl/tge_capture.sv
module tge_capture #(
  parameter int unsigned BITS = tge_pkg::DEF_BITS,
  localparam int unsigned TAPS = (1 << BITS) - 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            strobe,
  input  logic [TAPS-1:0] therm_d,
  output logic [TAPS-1:0] therm_q,
  output logic            held_vld
);
  always_ff @(posedge clk) begin
    if (rst) begin
      therm_q  <= '0;
      held_vld <= 1'b0;
    end else begin
      held_vld <= strobe;
      if (strobe) therm_q <= therm_d;
    end
  end
endmodule

// File: rtl/tge_gray_net.sv
module tge_gray_net #(
  parameter int unsigned BITS = tge_pkg::DEF_BITS,
  localparam int unsigned TAPS = (1 << BITS) - 1
) (
  input  logic [TAPS-1:0] therm,
  output logic [BITS-1:0] gray
);
  // tap k lives at therm[k-1]
  assign gray[BITS-1] = therm[(1 << (BITS-1)) - 1];

  for (genvar j = 0; j < BITS - 1; j++) begin : g_bit
    localparam int unsigned STEP = 1 << j;
    localparam int unsigned NP   = tge_pkg::pair_terms(BITS, j);
    logic [NP-1:0] terms;
    for (genvar m = 0; m < NP; m++) begin : g_pair
      localparam int unsigned LO = (4*m + 1) * STEP;
      localparam int unsigned HI = (4*m + 3) * STEP;
      assign terms[m] = therm[LO-1] & ~therm[HI-1];
    end
    assign gray[j] = |terms;
  end
endmodule

// File: rtl/tge_gray2bin.sv
module tge_gray2bin #(
  parameter int unsigned BITS = tge_pkg::DEF_BITS
) (
  input  logic [BITS-1:0] gray,
  output logic [BITS-1:0] bin
);
  always_comb begin
    bin[BITS-1] = gray[BITS-1];
    for (int i = BITS - 2; i >= 0; i--) begin
      bin[i] = bin[i+1] ^ gray[i];
    end
  end
endmodule

// File: rtl/therm_gray_enc.sv
module therm_gray_enc #(
  parameter int unsigned BITS = tge_pkg::DEF_BITS,
  localparam int unsigned TAPS = (1 << BITS) - 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sample_en,
  input  logic [TAPS-1:0] therm_in,
  output logic [BITS-1:0] code_out,
  output logic            code_valid
);
  logic [TAPS-1:0] therm_q;
  logic            held_vld;
  logic [BITS-1:0] gray_w;
  logic [BITS-1:0] bin_w;

  tge_capture #(.BITS(BITS)) u_cap (
    .clk     (clk),
    .rst     (rst),
    .strobe  (sample_en),
    .therm_d (therm_in),
    .therm_q (therm_q),
    .held_vld(held_vld)
  );

  tge_gray_net #(.BITS(BITS)) u_net (
    .therm(therm_q),
    .gray (gray_w)
  );

  tge_gray2bin #(.BITS(BITS)) u_g2b (
    .gray(gray_w),
    .bin (bin_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      code_out   <= '0;
      code_valid <= 1'b0;
    end else begin
      code_valid <= held_vld;
      if (held_vld) code_out <= bin_w;
    end
  end
endmodule

// File: rtl/tge_checker.sv
module tge_checker #(
  parameter int unsigned BITS = tge_pkg::DEF_BITS,
  localparam int unsigned TAPS = (1 << BITS) - 1
) (
  input logic            clk,
  input logic            rst,
  input logic            sample_en,
  input logic [TAPS-1:0] therm_in,
  input logic [BITS-1:0] code_out,
  input logic            code_valid
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (code_out == '0 && !code_valid)); // R1

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    sample_en |-> ##2 code_valid); // R2

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    code_valid |-> $past(sample_en, 2)); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !code_valid |-> $stable(code_out)); // R3

  AST_FULL_SCALE: assert property (@(posedge clk) disable iff (rst)
    (sample_en && therm_in == {TAPS{1'b1}}) |-> ##2 (code_out == {BITS{1'b1}})); // R5

  AST_ZERO_SCALE: assert property (@(posedge clk) disable iff (rst)
    (sample_en && therm_in == '0) |-> ##2 (code_out == '0)); // R5
endmodule

bind therm_gray_enc tge_checker #(.BITS(BITS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sample_en (sample_en),
  .therm_in  (therm_in),
  .code_out  (code_out),
  .code_valid(code_valid)
);

// File: tb/tb_therm_gray_enc.sv
module tb_therm_gray_enc;
  localparam int CLK_PERIOD = 10;
  localparam int BITS = 6;
  localparam int TAPS = (1 << BITS) - 1;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            sample_en = 1'b0;
  logic [TAPS-1:0] therm_in = '0;
  logic [BITS-1:0] code_out;
  logic            code_valid;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  therm_gray_enc #(.BITS(BITS)) dut (
    .clk(clk), .rst(rst), .sample_en(sample_en),
    .therm_in(therm_in), .code_out(code_out), .code_valid(code_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [TAPS-1:0] level_therm(input int lvl);
    logic [TAPS-1:0] t = '0;
    for (int k = 0; k < TAPS; k++) if (k < lvl) t[k] = 1'b1;
    return t;
  endfunction

  // independent model of the pair equations, by scanning every tap
  function automatic int model_code(input logic [TAPS-1:0] t);
    int g = 0;
    int b = 0;
    if (t[(1 << (BITS-1)) - 1]) g = g | (1 << (BITS-1));
    for (int j = 0; j < BITS - 1; j++) begin
      for (int k = 1; k + (2 << j) <= TAPS; k++) begin
        if ((k % (4 << j)) == (1 << j) && t[k-1] && !t[k + (2 << j) - 1])
          g = g | (1 << j);
      end
    end
    for (int i = BITS - 1; i >= 0; i--) begin
      int up = (i == BITS - 1) ? 0 : ((b >> (i+1)) & 1);
      b = b | ((up ^ ((g >> i) & 1)) << i);
    end
    return b;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  // one strobe, result checked two edges later
  task automatic sample(input logic [TAPS-1:0] t, output int got, output int vld);
    @(negedge clk);
    therm_in  = t;
    sample_en = 1'b1;
    @(negedge clk);
    sample_en = 1'b0;
    @(negedge clk);
    got = int'(code_out);
    vld = int'(code_valid);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 code", int'(code_out), 0);
    check("R1 valid", int'(code_valid), 0);
    rst = 1'b0;
  endtask

  task automatic t_sweep();
    int got, vld;
    for (int lvl = 0; lvl <= TAPS; lvl++) begin
      sample(level_therm(lvl), got, vld);
      check("R4 level", got, lvl);
      check("R2 valid", vld, 1);
    end
  endtask

  task automatic t_extremes();
    int got, vld;
    sample('0, got, vld);
    check("R5 zero", got, 0);
    sample({TAPS{1'b1}}, got, vld);
    check("R5 full", got, TAPS);
  endtask

  task automatic t_hold();
    int got, vld;
    sample(level_therm(21), got, vld);
    check("R3 base", got, 21);
    @(negedge clk);
    therm_in = level_therm(50);
    repeat (4) begin
      @(negedge clk);
      check("R3 hold code", int'(code_out), 21);
      check("R3 hold valid", int'(code_valid), 0);
    end
  endtask

  task automatic t_bubbles();
    int got, vld;
    for (int n = 0; n < 300; n++) begin
      int lvl = int'($urandom_range(TAPS, 0));
      int pos = int'($urandom_range(TAPS-1, 0));
      logic [TAPS-1:0] t = level_therm(lvl);
      int cg, og, diff;
      t[pos] = ~t[pos];
      sample(t, got, vld);
      check("R6 bubble model", got, model_code(t));
      cg = lvl ^ (lvl >> 1);
      og = got ^ (got >> 1);
      diff = $countones(cg ^ og);
      check("R7 gray distance", int'(diff <= 1), 1);
    end
  endtask

  task automatic t_back_to_back();
    int lv[8] = '{5, 62, 0, 33, 63, 17, 48, 1};
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        check("R2 stream code", int'(code_out), lv[i-2]);
        check("R2 stream valid", int'(code_valid), 1);
      end
      if (i < 8) begin
        therm_in  = level_therm(lv[i]);
        sample_en = 1'b1;
      end else begin
        sample_en = 1'b0;
      end
    end
    @(negedge clk);
    check("R2 single pulse", int'(code_valid), 0);
  endtask

  initial begin
    t_reset();
    t_sweep();
    t_extremes();
    t_hold();
    t_bubbles();
    t_back_to_back();
    done = 1'b1;
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule